// File: doc/BRIEF.md
# Fixed-Width Move/Store/Add Processor Core

This block is a small multi-cycle processor core with no accumulator. It fetches one 40-bit instruction word at a time from a synchronous instruction ROM and executes it. Its operations are a register load, a register copy, a register store and an integer add. They work over a file of general-purpose registers and a word-addressed data RAM. The program counter is the only special register a program can see. It steps by one instruction word after every instruction, because this core has no branches.

Each operation has one opcode for all of its addressing modes. A 4-bit mode field alone decides how the operands are formed. When the core decodes an opcode/mode pair it does not support, it raises a sticky trap output and stops. A program therefore ends itself by placing an unsupported word after its last instruction. A system reads the results from the data RAM once the trap is seen.

Top module: `mc40_core`

## Requirements
- R1: After reset is released, all registers read as zero and `trap` is low. The first fetch, of word address 0, is requested in the third clock cycle after the release.
- R2: Every legal instruction takes exactly three cycles: fetch, decode, execute. `imem_en` is high for one cycle in each instruction. The fetch address rises by one each time and wraps modulo 2^PC_W.
- R3: The word layout is opcode [39:32], mode [31:28], destination register [27:20], second register [19:12] and third register [11:4]. In each 8-bit register field, the low log2(NREG) bits pick the register and the upper bits are ignored.
- R4: Opcode 0xFF with mode 0 loads the destination register from RAM. The address is the field in bits [19:0], truncated to DADDR_W bits.
- R5: Opcode 0xFF with mode 1 loads the destination register from RAM. The address is the second register plus the zero-extended 12-bit displacement in bits [11:0], truncated to DADDR_W bits.
- R6: Opcode 0xFF with mode 3 copies the second register into the destination register.
- R7: Opcode 0xFE with mode 0 writes the destination-field register to RAM at the address in bits [19:0]. `dmem_wr` is high for exactly one cycle, two cycles after the fetch, and is never high together with `dmem_rd`.
- R8: Opcode 0xAA with mode 2 adds the zero-extended 20-bit immediate in bits [19:0] to the destination register, modulo 2^DATA_W.
- R9: Opcode 0xAA with mode 6 adds the second register to the destination register.
- R10: Opcode 0xAA with mode 7 writes the sum of the second and third registers into the destination register. This holds even when the destination is also one of the sources.
- R11: Any other opcode/mode pair raises `trap`. After that there is no further fetch, RAM read or RAM write, and `trap` stays high until reset.
- R12: A RAM read is requested in the decode cycle, one cycle after the fetch. The returned word is expected on `dmem_rdata` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_en | output | 1 | Instruction ROM read strobe |
| imem_addr | output | PC_W | Instruction word address (program counter) |
| imem_rdata | input | 40 | Instruction word, valid one cycle after the strobe |
| dmem_rd | output | 1 | Data RAM read strobe |
| dmem_wr | output | 1 | Data RAM write strobe |
| dmem_addr | output | DADDR_W | Data RAM word address |
| dmem_wdata | output | DATA_W | Data RAM write data |
| dmem_rdata | input | DATA_W | Data RAM read data, valid one cycle after the strobe |
| trap | output | 1 | Sticky flag: unsupported instruction decoded, core stopped |

## Verification
A wrong register value stays hidden until a store moves it to RAM. The bench therefore ends each program with stores, and a corrupted register shows up in the RAM image at the end of the run. A wrong sequencer state shows at the ports within one instruction. It appears as a fetch outside the three-cycle rhythm, a skipped or repeated fetch address, or a RAM strobe in the wrong slot, and the bench times each of these against the last fetch. A wrong decode either raises the trap early, which cuts the fetch count short, or lets execution continue after an unsupported word.

// File: rtl/mc40_pkg.sv
package mc40_pkg;
  localparam int INSTR_W = 40;

  localparam logic [7:0] OP_MOVE  = 8'hFF;
  localparam logic [7:0] OP_STORE = 8'hFE;
  localparam logic [7:0] OP_ADD   = 8'hAA;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_TRAP
  } state_e;

  typedef enum logic [2:0] {
    K_LD_ABS,
    K_LD_IDX,
    K_CPY,
    K_ST_ABS,
    K_ADD_IMM,
    K_ADD_ACC,
    K_ADD_3OP
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic        bad;
    logic [7:0]  rd;
    logic [7:0]  rs;
    logic [7:0]  rt;
    logic [19:0] field20;
    logic [11:0] disp;
  } dec_t;
endpackage

// File: rtl/mc40_rst_sync.sv
module mc40_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mc40_decode.sv
module mc40_decode
  import mc40_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [7:0] opcode;
  logic [3:0] mode;

  assign opcode = instr[39:32];
  assign mode   = instr[31:28];

  always_comb begin
    dec.kind    = K_CPY;
    dec.bad     = 1'b0;
    dec.rd      = instr[27:20];
    dec.rs      = instr[19:12];
    dec.rt      = instr[11:4];
    dec.field20 = instr[19:0];
    dec.disp    = instr[11:0];
    case (opcode)
      OP_MOVE: begin
        case (mode)
          4'd0:    dec.kind = K_LD_ABS;
          4'd1:    dec.kind = K_LD_IDX;
          4'd3:    dec.kind = K_CPY;
          default: dec.bad  = 1'b1;
        endcase
      end
      OP_STORE: begin
        if (mode == 4'd0) dec.kind = K_ST_ABS;
        else              dec.bad  = 1'b1;
      end
      OP_ADD: begin
        case (mode)
          4'd2:    dec.kind = K_ADD_IMM;
          4'd6:    dec.kind = K_ADD_ACC;
          4'd7:    dec.kind = K_ADD_3OP;
          default: dec.bad  = 1'b1;
        endcase
      end
      default: dec.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/mc40_regfile.sv
module mc40_regfile #(
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RIDX_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [RIDX_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = we && (waddr == RIDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[i] <= '0;
      else if (hit) regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mc40_seq.sv
module mc40_seq
  import mc40_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_bad,
  output state_e          state_q,
  output logic [PC_W-1:0] pc_q
);
  state_e          state_d;
  logic [PC_W-1:0] pc_d;
  logic            pc_en;

  always_comb begin
    state_d = state_q;
    pc_en   = 1'b0;
    case (state_q)
      ST_IDLE:   state_d = ST_FETCH;
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = dec_bad ? ST_TRAP : ST_EXEC;
      ST_EXEC: begin
        state_d = ST_FETCH;
        pc_en   = 1'b1;
      end
      default:   state_d = ST_TRAP;
    endcase
  end

  assign pc_d = pc_q + PC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en) pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/mc40_core.sv
module mc40_core
  import mc40_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int DADDR_W = 8,
  parameter int DATA_W  = 32,
  parameter int NREG    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               imem_en,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic               dmem_rd,
  output logic               dmem_wr,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic               trap
);
  localparam int RIDX_W = $clog2(NREG);

  logic              rst_int_n;
  state_e            state_q;
  logic [PC_W-1:0]   pc_q;
  dec_t              dec_now;
  logic              in_decode;
  logic              in_exec;

  logic [RIDX_W-1:0] ra_a, ra_b;
  logic [DATA_W-1:0] rd_a, rd_b;
  logic [DATA_W-1:0] addr_calc;
  logic              is_load;

  kind_e             kind_q;
  logic [RIDX_W-1:0] dst_q;
  logic [19:0]       imm_q;
  logic [DATA_W-1:0] opa_q, opb_q;
  logic [DADDR_W-1:0] maddr_q;

  logic              rf_we;
  logic [DATA_W-1:0] rf_wdata;

  mc40_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mc40_decode u_decode (
    .instr (imem_rdata),
    .dec   (dec_now)
  );

  mc40_seq #(.PC_W(PC_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .dec_bad (dec_now.bad),
    .state_q (state_q),
    .pc_q    (pc_q)
  );

  assign in_decode = (state_q == ST_DECODE);
  assign in_exec   = (state_q == ST_EXEC);

  // Operand selection happens while the fresh word sits on imem_rdata.
  always_comb begin
    case (dec_now.kind)
      K_ST_ABS, K_ADD_IMM, K_ADD_ACC: ra_a = dec_now.rd[RIDX_W-1:0];
      default:                        ra_a = dec_now.rs[RIDX_W-1:0];
    endcase
    ra_b = (dec_now.kind == K_ADD_ACC) ? dec_now.rs[RIDX_W-1:0]
                                       : dec_now.rt[RIDX_W-1:0];
  end

  mc40_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we      (rf_we),
    .waddr   (dst_q),
    .wdata   (rf_wdata),
    .raddr_a (ra_a),
    .rdata_a (rd_a),
    .raddr_b (ra_b),
    .rdata_b (rd_b)
  );

  assign addr_calc = (dec_now.kind == K_LD_IDX)
                   ? rd_a + DATA_W'(dec_now.disp)
                   : DATA_W'(dec_now.field20);
  assign is_load   = (dec_now.kind == K_LD_ABS) || (dec_now.kind == K_LD_IDX);

  // Capture the decoded instruction and its operands at the end of decode.
  always_ff @(posedge clk) begin
    if (in_decode) begin
      kind_q  <= dec_now.kind;
      dst_q   <= dec_now.rd[RIDX_W-1:0];
      imm_q   <= dec_now.field20;
      opa_q   <= rd_a;
      opb_q   <= rd_b;
      maddr_q <= addr_calc[DADDR_W-1:0];
    end
  end

  always_comb begin
    case (kind_q)
      K_LD_ABS, K_LD_IDX: rf_wdata = dmem_rdata;
      K_CPY:              rf_wdata = opa_q;
      K_ADD_IMM:          rf_wdata = opa_q + DATA_W'(imm_q);
      default:            rf_wdata = opa_q + opb_q;
    endcase
  end

  assign rf_we      = in_exec && (kind_q != K_ST_ABS);

  assign imem_en    = (state_q == ST_FETCH);
  assign imem_addr  = pc_q;
  assign dmem_rd    = in_decode && !dec_now.bad && is_load;
  assign dmem_wr    = in_exec && (kind_q == K_ST_ABS);
  assign dmem_addr  = in_decode ? addr_calc[DADDR_W-1:0] : maddr_q;
  assign dmem_wdata = opa_q;
  assign trap       = (state_q == ST_TRAP);

  logic unused_hi;
  assign unused_hi = ^{dec_now.rd[7:RIDX_W], dec_now.rs[7:RIDX_W],
                       dec_now.rt[7:RIDX_W], addr_calc[DATA_W-1:DADDR_W]};
endmodule

// File: rtl/mc40_checker.sv
module mc40_checker #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            imem_en,
  input logic [PC_W-1:0] imem_addr,
  input logic            dmem_rd,
  input logic            dmem_wr,
  input logic            trap
);
  logic            seen_q;
  logic [PC_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else if (imem_en) begin
      seen_q <= 1'b1;
      prev_q <= imem_addr;
    end
  end

  assert_fetch_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_en |=> !imem_en);
  assert_fetch_gap2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_en |=> ##1 !imem_en);
  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_en && seen_q) |-> (imem_addr == prev_q + PC_W'(1)));
  assert_rw_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_rd && dmem_wr));
  assert_wr_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_wr |-> $past(imem_en, 2));
  assert_rd_slot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd |-> $past(imem_en));
  assert_trap_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> trap);
  assert_trap_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (!imem_en && !dmem_wr && !dmem_rd));
endmodule

bind mc40_core mc40_checker #(.PC_W(PC_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_en   (imem_en),
  .imem_addr (imem_addr),
  .dmem_rd   (dmem_rd),
  .dmem_wr   (dmem_wr),
  .trap      (trap)
);

// File: tb/mc40_core_bench.sv
module mc40_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 8;
  localparam int DADDR_W = 8;
  localparam int DATA_W = 32;

  logic               clk;
  logic               rst_n;
  logic               imem_en;
  logic [PC_W-1:0]    imem_addr;
  logic [39:0]        imem_rdata;
  logic               dmem_rd;
  logic               dmem_wr;
  logic [DADDR_W-1:0] dmem_addr;
  logic [DATA_W-1:0]  dmem_wdata;
  logic [DATA_W-1:0]  dmem_rdata;
  logic               trap;

  int checks = 0;
  int fails  = 0;

  logic [39:0]        rom [0:63];
  logic [DATA_W-1:0]  ram [0:(1<<DADDR_W)-1];
  logic               ld_rom, ld_ram;
  logic [7:0]         ld_addr;
  logic [39:0]        ld_ins;
  logic [DATA_W-1:0]  ld_data;

  int fetch_cnt, first_fetch, slot_bad, quiet_bad;
  logic trapped;

  mc40_core #(.PC_W(PC_W), .DADDR_W(DADDR_W), .DATA_W(DATA_W), .NREG(16)) u_mc40_core (
    .clk(clk), .rst_n(rst_n), .imem_en(imem_en), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .trap(trap)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (ld_rom) rom[ld_addr[5:0]] <= ld_ins;
    if (imem_en) imem_rdata <= rom[imem_addr[5:0]];
    if (ld_ram) ram[ld_addr] <= ld_data;
    else if (dmem_wr) ram[dmem_addr] <= dmem_wdata;
    if (dmem_rd) dmem_rdata <= ram[dmem_addr];
  end

  function automatic logic [39:0] iw(input logic [7:0] op, input logic [3:0] md,
                                     input logic [7:0] rd, input logic [19:0] f);
    return {op, md, rd, f};
  endfunction

  function automatic logic [39:0] ir(input logic [7:0] op, input logic [3:0] md,
                                     input logic [7:0] rd, input logic [7:0] rs,
                                     input logic [7:0] rt);
    return {op, md, rd, rs, rt, 4'h0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_rom(input int a, input logic [39:0] w);
    ld_rom = 1'b1; ld_addr = 8'(a); ld_ins = w;
    @(negedge clk);
    ld_rom = 1'b0;
  endtask

  task automatic put_ram(input int a, input logic [DATA_W-1:0] d);
    ld_ram = 1'b1; ld_addr = 8'(a); ld_data = d;
    @(negedge clk);
    ld_ram = 1'b0;
  endtask

  task automatic start_test();
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < 64; a++) put_rom(a, 40'h0);
    for (int a = 0; a < (1<<DADDR_W); a++) put_ram(a, 32'hFFFF_FFFF);
  endtask

  // Release reset and watch the ports until the trap, timing every strobe.
  task automatic run_prog(input int max_cyc);
    int cyc;
    int last_fetch;
    logic [PC_W-1:0] exp_addr;
    cyc = 0; last_fetch = -100; exp_addr = '0;
    fetch_cnt = 0; first_fetch = -1; slot_bad = 0; quiet_bad = 0; trapped = 1'b0;
    rst_n = 1'b1;
    while (cyc < max_cyc && !trapped) begin
      @(negedge clk);
      cyc++;
      if (imem_en) begin
        if (first_fetch < 0) first_fetch = cyc;
        else if (cyc - last_fetch != 3) slot_bad++;
        if (imem_addr != exp_addr) slot_bad++;
        exp_addr = exp_addr + PC_W'(1);
        last_fetch = cyc;
        fetch_cnt++;
      end
      if (dmem_rd && (cyc - last_fetch != 1)) slot_bad++;
      if (dmem_wr && (cyc - last_fetch != 2)) slot_bad++;
      if (dmem_rd && dmem_wr) slot_bad++;
      if (trap) trapped = 1'b1;
    end
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (imem_en || dmem_wr || dmem_rd || !trap) quiet_bad++;
    end
  endtask

  task automatic test_reset();
    start_test();
    chk(trap == 1'b0, "R1 trap low in reset", trap, 0);
    put_ram(8'h70, 32'h1234_5678);
    put_rom(0, iw(8'hFE, 4'd0, 8'h09, 20'h00070));
    put_rom(1, iw(8'hFE, 4'd0, 8'h00, 20'h00071));
    run_prog(200);
    chk(first_fetch == 3, "R1 first fetch cycle", first_fetch, 3);
    chk(ram[8'h70] == 32'h0, "R1 R9 zero after reset", ram[8'h70], 0);
    chk(ram[8'h71] == 32'h0, "R1 R0 zero after reset", ram[8'h71], 0);
    chk(slot_bad == 0, "R7 store slot timing", slot_bad, 0);
  endtask

  task automatic test_moves();
    start_test();
    put_ram(8'h10, 32'hDEAD_BEEF);
    put_ram(8'h11, 32'h0000_0020);
    put_ram(8'h25, 32'h0BAD_F00D);
    put_rom(0, iw(8'hFF, 4'd0, 8'h01, 20'hABC10));      // R4: high addr bits dropped
    put_rom(1, iw(8'hFF, 4'd0, 8'h05, 20'h00011));
    put_rom(2, {8'hFF, 4'd1, 8'h06, 8'h05, 12'h005});   // R5: 0x20 + 5
    put_rom(3, ir(8'hFF, 4'd3, 8'h13, 8'h01, 8'h00));   // R6/R3: field 0x13 -> reg 3
    put_rom(4, iw(8'hFE, 4'd0, 8'h03, 20'h00040));
    put_rom(5, iw(8'hFE, 4'd0, 8'h06, 20'h00041));
    put_rom(6, iw(8'hFE, 4'd0, 8'hF5, 20'h00042));      // R3: field 0xF5 -> reg 5
    run_prog(400);
    chk(trapped, "R11 trap at program end", trapped, 1);
    chk(fetch_cnt == 8, "R2 fetch count", fetch_cnt, 8);
    chk(slot_bad == 0, "R2 R12 strobe timing", slot_bad, 0);
    chk(ram[8'h40] == 32'hDEAD_BEEF, "R4 R6 direct load and copy", ram[8'h40], 32'hDEAD_BEEF);
    chk(ram[8'h41] == 32'h0BAD_F00D, "R5 indexed load", ram[8'h41], 32'h0BAD_F00D);
    chk(ram[8'h42] == 32'h20, "R3 upper register bits ignored", ram[8'h42], 32'h20);
    chk(ram[8'h43] == 32'hFFFF_FFFF, "R7 no stray write", ram[8'h43], 32'hFFFF_FFFF);
  endtask

  task automatic test_adds();
    start_test();
    put_ram(8'h30, 32'hFFFF_FFF0);
    put_ram(8'h31, 32'h0000_0005);
    put_rom(0, iw(8'hFF, 4'd0, 8'h01, 20'h00030));
    put_rom(1, iw(8'hAA, 4'd2, 8'h01, 20'h00020));      // R8: wraps to 0x10
    put_rom(2, iw(8'hFF, 4'd0, 8'h02, 20'h00031));
    put_rom(3, ir(8'hAA, 4'd6, 8'h02, 8'h01, 8'h00));   // R9: 5 + 0x10
    put_rom(4, ir(8'hAA, 4'd7, 8'h03, 8'h01, 8'h02));   // R10: 0x10 + 0x15
    put_rom(5, ir(8'hAA, 4'd7, 8'h02, 8'h02, 8'h02));   // R10: 0x15 + 0x15
    put_rom(6, iw(8'hAA, 4'd2, 8'h04, 20'hFFFFF));      // R8: full immediate
    put_rom(7, iw(8'hFE, 4'd0, 8'h01, 20'h00050));
    put_rom(8, iw(8'hFE, 4'd0, 8'h02, 20'h00051));
    put_rom(9, iw(8'hFE, 4'd0, 8'h03, 20'h00052));
    put_rom(10, iw(8'hFE, 4'd0, 8'h04, 20'h00053));
    run_prog(600);
    chk(fetch_cnt == 12, "R2 fetch count adds", fetch_cnt, 12);
    chk(slot_bad == 0, "R2 strobe timing adds", slot_bad, 0);
    chk(ram[8'h50] == 32'h10, "R8 immediate add wrap", ram[8'h50], 32'h10);
    chk(ram[8'h51] == 32'h2A, "R10 sources equal destination", ram[8'h51], 32'h2A);
    chk(ram[8'h52] == 32'h25, "R9 R10 accumulate and three-operand", ram[8'h52], 32'h25);
    chk(ram[8'h53] == 32'h000F_FFFF, "R8 zero-extended immediate", ram[8'h53], 32'h000F_FFFF);
  endtask

  task automatic test_illegal(input logic [39:0] bad_word, input string tag);
    start_test();
    put_ram(8'h10, 32'hDEAD_BEEF);
    put_ram(8'h60, 32'h5555_5555);
    put_rom(0, iw(8'hFF, 4'd0, 8'h01, 20'h00010));
    put_rom(1, bad_word);
    put_rom(2, iw(8'hFE, 4'd0, 8'h01, 20'h00060));
    run_prog(200);
    chk(trapped, {"R11 trap raised ", tag}, trapped, 1);
    chk(fetch_cnt == 2, {"R11 fetches stop ", tag}, fetch_cnt, 2);
    chk(quiet_bad == 0, {"R11 quiet and sticky ", tag}, quiet_bad, 0);
    chk(ram[8'h60] == 32'h5555_5555, {"R11 later store suppressed ", tag},
        ram[8'h60], 32'h5555_5555);
  endtask

  initial begin
    rst_n = 1'b0; ld_rom = 1'b0; ld_ram = 1'b0; ld_addr = '0; ld_ins = '0; ld_data = '0;
    test_reset();
    test_moves();
    test_adds();
    test_illegal(iw(8'hFF, 4'd2, 8'h01, 20'h0), "move mode 2");
    test_illegal(iw(8'hFE, 4'd1, 8'h01, 20'h60), "store mode 1");
    test_illegal(iw(8'hAB, 4'd2, 8'h01, 20'h1), "unknown opcode");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule